// File: doc/BRIEF.md
# Gigabit Ethernet Controller Command and Status Register Block

This block is the software-visible control face of a gigabit Ethernet controller. A host reaches it over a plain 32-bit bus. Each access gives a 12-bit byte offset, a write flag and write data, and the block answers every access one cycle later with a response strobe, read data and an error flag. The block holds these registers:

- a command register that starts, stops and resets the transmit and receive DMA engines;
- a configuration register whose hardware status fields cannot be overwritten;
- a built-in-self-test control register;
- an interrupt status, mask and enable set;
- the two descriptor base pointers.

A 128-byte statistics window reads as zero.

The two engine-control outputs are levels (enable). The kick and reset outputs are one-cycle pulses. A kick restarts an engine that is idle. The block also drives one interrupt request line. Event inputs from the datapath set sticky interrupt status bits. Software clears those bits by reading the status register.

Top module: `nic_ctrl_regs`

## Requirements
- R1: Registers sit at these word-aligned offsets, and a write followed by a read returns the stored value: command 0x000, configuration 0x004, test control 0x008, interrupt status 0x00C, interrupt mask 0x010, interrupt enable 0x014, transmit descriptor pointer 0x018, receive descriptor pointer 0x01C.
- R2: These accesses return the error flag, read data 0, and change no register: offsets 0x020 to 0x07F, offsets 0x100 and above, and any offset whose two low bits are not zero.
- R3: The statistics window, offsets 0x080 to 0x0FF, reads as 0 without error, and writes to it are ignored without error.
- R4: Every access, and only an access, is followed one cycle later by a response strobe carrying the read data (0 for writes) and the error flag.
- R5: A command read returns the stored word with bit 1 (transmit off), bit 3 (receive off), bit 4 (transmit reset) and bit 5 (receive reset) forced to 0.
- R6: In a command write, an engine's off bit (1 for transmit, 3 for receive) overrides its on bit (0 for transmit, 2 for receive). An on bit that takes effect sets the engine enable. If that engine's idle input is high, it also raises the engine's kick output for exactly the cycle after the write.
- R7: Command bit 4 or 5 pulses the matching engine reset output for one cycle. Command bit 8 overrides every other bit in the same write. It pulses both engine resets, clears both enables, and returns every register to its default: all zero except the configuration status fields.
- R8: Command bit 7 sets interrupt status bit 8.
- R9: Interrupt status bits 7:0 are sticky copies of the event inputs. A status read returns the contents and then clears them. An event arriving in the same cycle as that read is kept. A write to the status register returns the error flag and changes nothing.
- R10: The interrupt request is high exactly when interrupt enable bit 0 is set and some status bit is also set in the mask.
- R11: A configuration write leaves the bits in the read-only mask unchanged (default 0xF0001007: link, speed, duplex, 64-bit detect and reserved). All other bits take the written data. The default value is 0x00001005.
- R12: A transmit descriptor pointer write stores the data with bits 1:0 cleared. It is legal only while the transmit idle input is high; otherwise the write returns the error flag and stores nothing.
- R13: In test control, writing bit 0 sets bit 1 (done) in the same write. Bit 1 cannot be written. Bits 2 and 3 always read as 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after an access |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was illegal |
| tx_idle | input | 1 | Transmit engine is idle |
| rx_idle | input | 1 | Receive engine is idle |
| ev_in | input | N_EV | Interrupt event pulses from the datapath |
| tx_en | output | 1 | Transmit engine enable |
| rx_en | output | 1 | Receive engine enable |
| tx_kick | output | 1 | Transmit restart pulse |
| rx_kick | output | 1 | Receive restart pulse |
| tx_rst | output | 1 | Transmit engine reset pulse |
| rx_rst | output | 1 | Receive engine reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an event arriving in exactly the cycle when a status read clears the register. If the clear wins, that event is lost without trace. The stimulus drives an event pulse on the same clock edge that samples the status read. It then expects the read to return the old contents and a second read to return only the new event bit. A global reset written together with an engine on bit, while interrupts are pending, is driven the same way. This shows that the reset overrides the kick, the enables and the interrupt line.

// File: rtl/nic_regs_pkg.sv
// Shared offsets, bit positions and selector type for the controller register block.
// Assumes a 12-bit byte offset and 32-bit data words.
package nic_regs_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CMD      = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG      = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_TEST     = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_ISR      = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_IMR      = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_IER      = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_TXDP     = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_RXDP     = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_RSV_BEG  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_RSV_END  = 12'h07F;
    localparam logic [ADDR_W-1:0] OFF_STAT_BEG = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_STAT_END = 12'h0FF;

    // command word bit positions
    localparam int CMD_TX_ON    = 0;
    localparam int CMD_TX_OFF   = 1;
    localparam int CMD_RX_ON    = 2;
    localparam int CMD_RX_OFF   = 3;
    localparam int CMD_TX_CLR   = 4;
    localparam int CMD_RX_CLR   = 5;
    localparam int CMD_SOFT_IRQ = 7;
    localparam int CMD_FULL_RST = 8;
    localparam logic [DATA_W-1:0] CMD_RD_MASK =
        ~((DATA_W'(1) << CMD_TX_OFF) | (DATA_W'(1) << CMD_RX_OFF) |
          (DATA_W'(1) << CMD_TX_CLR) | (DATA_W'(1) << CMD_RX_CLR));

    // test control bit positions
    localparam int TST_RBIST_GO  = 0;
    localparam int TST_RBIST_OK  = 1;
    localparam int TST_EEBIST_GO = 2;
    localparam int TST_EELOAD_GO = 3;

    // engine indices
    localparam int N_ENG  = 2;
    localparam int ENG_TX = 0;
    localparam int ENG_RX = 1;

    typedef enum logic [3:0] {
        SEL_CMD, SEL_CFG, SEL_TEST, SEL_ISR, SEL_IMR,
        SEL_IER, SEL_TXDP, SEL_RXDP, SEL_STATS, SEL_BAD
    } reg_sel_e;
endpackage

// File: rtl/nic_reg_decode.sv
// Offset decoder: maps a byte offset to a register selector.
// Misaligned, reserved and out-of-range offsets all map to SEL_BAD. Purely combinational.
module nic_reg_decode
    import nic_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // select the register addressed by this offset
    always_comb begin
        if (addr[1:0] != 2'b00) begin
            sel = SEL_BAD;
        end else if (addr >= OFF_STAT_BEG && addr <= OFF_STAT_END) begin
            sel = SEL_STATS;
        end else begin
            case (addr)
                OFF_CMD:  sel = SEL_CMD;
                OFF_CFG:  sel = SEL_CFG;
                OFF_TEST: sel = SEL_TEST;
                OFF_ISR:  sel = SEL_ISR;
                OFF_IMR:  sel = SEL_IMR;
                OFF_IER:  sel = SEL_IER;
                OFF_TXDP: sel = SEL_TXDP;
                OFF_RXDP: sel = SEL_RXDP;
                default:  sel = SEL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/nic_engine_ctl.sv
// Per-engine control: holds the enable level and produces the one-cycle kick and reset pulses.
// Assumes cmd_wr is high for a single accepted command write. Global reset overrides the
// other bits of that write.
module nic_engine_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic glob_rst,
    input  logic on_bit,
    input  logic off_bit,
    input  logic clr_bit,
    input  logic idle,
    output logic en_q,
    output logic kick_q,
    output logic clr_q
);
    // apply command bits with precedence: global reset, then off, then on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            kick_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            kick_q <= 1'b0;
            clr_q  <= 1'b0;
            if (cmd_wr) begin
                if (glob_rst) begin
                    en_q  <= 1'b0;
                    clr_q <= 1'b1;
                end else begin
                    if (off_bit) begin
                        en_q <= 1'b0;
                    end else if (on_bit) begin
                        en_q   <= 1'b1;
                        kick_q <= idle;
                    end
                    clr_q <= clr_bit;
                end
            end
        end
    end
endmodule

// File: rtl/nic_irq_ctrl.sv
// Interrupt status, mask and enable registers.
// Status bits [N_EV-1:0] latch the event inputs; bit N_EV latches the software interrupt.
// A status read clears the register, but new events in that cycle are kept.
// Assumes N_EV < DATA_W.
module nic_irq_ctrl #(
    parameter int N_EV   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              rd_clr,
    input  logic              swi_post,
    input  logic [N_EV-1:0]   ev_in,
    input  logic              wr_imr,
    input  logic              wr_ier,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] isr_q,
    output logic [DATA_W-1:0] imr_q,
    output logic [DATA_W-1:0] ier_q,
    output logic              irq
);
    localparam int SWI_BIT = N_EV;

    logic [DATA_W-1:0] set_vec;

    // gather this cycle's new status sources
    always_comb begin
        set_vec                = '0;
        set_vec[N_EV-1:0]      = ev_in;
        set_vec[SWI_BIT]       = swi_post;
    end

    // status register: set wins over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            isr_q <= '0;
        end else begin
            isr_q <= (rd_clr ? '0 : isr_q) | set_vec;
        end
    end

    // mask and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            imr_q <= '0;
            ier_q <= '0;
        end else begin
            if (wr_imr) imr_q <= wdata;
            if (wr_ier) ier_q <= wdata;
        end
    end

    // request line from pending, unmasked, globally enabled status
    assign irq = ier_q[0] & (|(isr_q & imr_q));
endmodule

// File: rtl/nic_ctrl_regs.sv
// Top of the controller command/status register block.
// Decodes bus accesses, rejects illegal ones, holds the configuration, test and pointer
// registers, and answers every access one cycle later. Engine control and interrupt
// logic live in sub-blocks. Assumes at most one access per cycle.
module nic_ctrl_regs
    import nic_regs_pkg::*;
#(
    parameter int                N_EV        = 8,
    parameter logic [DATA_W-1:0] CFG_RO_MASK = 32'hF000_1007,
    parameter logic [DATA_W-1:0] CFG_RESET   = 32'h0000_1005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              tx_idle,
    input  logic              rx_idle,
    input  logic [N_EV-1:0]   ev_in,
    output logic              tx_en,
    output logic              rx_en,
    output logic              tx_kick,
    output logic              rx_kick,
    output logic              tx_rst,
    output logic              rx_rst,
    output logic              irq
);
    localparam logic [DATA_W-1:0] PTR_ALIGN = ~DATA_W'(3);

    reg_sel_e          sel;
    logic              acc_wr, acc_rd, wr_bad, err_now, do_wr;
    logic              wr_cmd, full_rst;
    logic [DATA_W-1:0] cmd_q, cfg_q, test_q, txdp_q, rxdp_q;
    logic [DATA_W-1:0] isr_q, imr_q, ier_q;
    logic [DATA_W-1:0] test_nxt, rd_mux;
    logic [N_ENG-1:0]  eng_idle, eng_en, eng_kick, eng_clr;

    nic_reg_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // classify the access and decide whether a write may take effect
    always_comb begin
        acc_wr   = bus_valid & bus_write;
        acc_rd   = bus_valid & ~bus_write;
        wr_bad   = acc_wr & ((sel == SEL_ISR) | ((sel == SEL_TXDP) & ~tx_idle));
        err_now  = (bus_valid & (sel == SEL_BAD)) | wr_bad;
        do_wr    = acc_wr & ~err_now;
        wr_cmd   = do_wr & (sel == SEL_CMD);
        full_rst = wr_cmd & bus_wdata[CMD_FULL_RST];
    end

    // engine controllers, one per DMA direction
    assign eng_idle[ENG_TX] = tx_idle;
    assign eng_idle[ENG_RX] = rx_idle;

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        localparam int ON_B  = (e == ENG_TX) ? CMD_TX_ON  : CMD_RX_ON;
        localparam int OFF_B = (e == ENG_TX) ? CMD_TX_OFF : CMD_RX_OFF;
        localparam int CLR_B = (e == ENG_TX) ? CMD_TX_CLR : CMD_RX_CLR;
        nic_engine_ctl u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_wr   (wr_cmd),
            .glob_rst (full_rst),
            .on_bit   (bus_wdata[ON_B]),
            .off_bit  (bus_wdata[OFF_B]),
            .clr_bit  (bus_wdata[CLR_B]),
            .idle     (eng_idle[e]),
            .en_q     (eng_en[e]),
            .kick_q   (eng_kick[e]),
            .clr_q    (eng_clr[e])
        );
    end

    assign tx_en   = eng_en[ENG_TX];
    assign rx_en   = eng_en[ENG_RX];
    assign tx_kick = eng_kick[ENG_TX];
    assign rx_kick = eng_kick[ENG_RX];
    assign tx_rst  = eng_clr[ENG_TX];
    assign rx_rst  = eng_clr[ENG_RX];

    nic_irq_ctrl #(
        .N_EV   (N_EV),
        .DATA_W (DATA_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (full_rst),
        .rd_clr   (acc_rd & (sel == SEL_ISR)),
        .swi_post (wr_cmd & bus_wdata[CMD_SOFT_IRQ]),
        .ev_in    (ev_in),
        .wr_imr   (do_wr & (sel == SEL_IMR)),
        .wr_ier   (do_wr & (sel == SEL_IER)),
        .wdata    (bus_wdata),
        .isr_q    (isr_q),
        .imr_q    (imr_q),
        .ier_q    (ier_q),
        .irq      (irq)
    );

    // test control next value: done follows go, EEPROM bits self-clear
    always_comb begin
        test_nxt                = bus_wdata;
        test_nxt[TST_RBIST_OK]  = bus_wdata[TST_RBIST_GO];
        test_nxt[TST_EEBIST_GO] = 1'b0;
        test_nxt[TST_EELOAD_GO] = 1'b0;
    end

    // command, configuration, test and pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n || full_rst) begin
            cmd_q  <= '0;
            cfg_q  <= CFG_RESET;
            test_q <= '0;
            txdp_q <= '0;
            rxdp_q <= '0;
        end else if (do_wr) begin
            case (sel)
                SEL_CMD:  cmd_q  <= bus_wdata;
                SEL_CFG:  cfg_q  <= (cfg_q & CFG_RO_MASK) | (bus_wdata & ~CFG_RO_MASK);
                SEL_TEST: test_q <= test_nxt;
                SEL_TXDP: txdp_q <= bus_wdata & PTR_ALIGN;
                SEL_RXDP: rxdp_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // read data selection
    always_comb begin
        case (sel)
            SEL_CMD:  rd_mux = cmd_q & CMD_RD_MASK;
            SEL_CFG:  rd_mux = cfg_q;
            SEL_TEST: rd_mux = test_q;
            SEL_ISR:  rd_mux = isr_q;
            SEL_IMR:  rd_mux = imr_q;
            SEL_IER:  rd_mux = ier_q;
            SEL_TXDP: rd_mux = txdp_q;
            SEL_RXDP: rd_mux = rxdp_q;
            default:  rd_mux = '0;
        endcase
    end

    // one-cycle response path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_err   <= err_now;
            rsp_rdata <= (acc_rd && !err_now) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/nic_ctrl_regs_chk.sv
// Property checker for the controller register block, attached to every instance by bind.
// Observes the top-level ports only.
module nic_ctrl_regs_chk
    import nic_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              tx_en,
    input logic              rx_en,
    input logic              tx_kick,
    input logic              rx_kick,
    input logic              irq
);
    logic wr_cmd_p;
    assign wr_cmd_p = bus_valid && bus_write && (bus_addr == OFF_CMD);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid); // R4
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !rsp_valid); // R4
    AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr >= OFF_RSV_BEG && bus_addr <= OFF_RSV_END) |=> rsp_err); // R2
    AST_STATS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[1:0] == 2'b00 &&
         bus_addr >= OFF_STAT_BEG && bus_addr <= OFF_STAT_END)
        |=> (rsp_rdata == '0 && !rsp_err)); // R3
    AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_p && bus_wdata[CMD_TX_OFF]) |=> !tx_en); // R6
    AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_p && bus_wdata[CMD_RX_OFF]) |=> !rx_en); // R6
    AST_KICK_WITH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_kick |-> tx_en) and (rx_kick |-> rx_en)); // R6
    AST_ISR_WRITE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFF_ISR) |=> rsp_err); // R9
    AST_FULL_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_p && bus_wdata[CMD_FULL_RST])
        |=> (!tx_en && !rx_en && !tx_kick && !rx_kick && !irq)); // R7
endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .tx_kick   (tx_kick),
    .rx_kick   (rx_kick),
    .irq       (irq)
);

// File: tb/nic_ctrl_regs_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests for reset,
// command precedence, interrupt behaviour and the global reset.
module nic_ctrl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_EV       = 8;
    localparam int N_VEC      = 24;

    typedef struct packed {
        logic [23:0] tag;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{"R11", 1'b0, 12'h004, 32'h0,        32'h0000_1005, 1'b0},
        '{"R11", 1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0,        1'b0},
        '{"R11", 1'b0, 12'h004, 32'h0,        32'h0FFF_FFFD, 1'b0},
        '{"R11", 1'b1, 12'h004, 32'h0,        32'h0,         1'b0},
        '{"R11", 1'b0, 12'h004, 32'h0,        32'h0000_1005, 1'b0},
        '{"R12", 1'b1, 12'h018, 32'h1234_5677, 32'h0,        1'b0},
        '{"R12", 1'b0, 12'h018, 32'h0,        32'h1234_5674, 1'b0},
        '{"R1 ", 1'b1, 12'h01C, 32'hDEAD_BEEF, 32'h0,        1'b0},
        '{"R1 ", 1'b0, 12'h01C, 32'h0,        32'hDEAD_BEEF, 1'b0},
        '{"R1 ", 1'b1, 12'h010, 32'h0000_00A5, 32'h0,        1'b0},
        '{"R1 ", 1'b0, 12'h010, 32'h0,        32'h0000_00A5, 1'b0},
        '{"R3 ", 1'b0, 12'h080, 32'h0,        32'h0,         1'b0},
        '{"R3 ", 1'b1, 12'h0FC, 32'h0000_FFFF, 32'h0,        1'b0},
        '{"R3 ", 1'b0, 12'h0FC, 32'h0,        32'h0,         1'b0},
        '{"R2 ", 1'b0, 12'h020, 32'h0,        32'h0,         1'b1},
        '{"R2 ", 1'b1, 12'h07C, 32'hFFFF_FFFF, 32'h0,        1'b1},
        '{"R2 ", 1'b0, 12'h100, 32'h0,        32'h0,         1'b1},
        '{"R2 ", 1'b0, 12'hFFC, 32'h0,        32'h0,         1'b1},
        '{"R2 ", 1'b1, 12'h002, 32'h0000_01FF, 32'h0,        1'b1},
        '{"R2 ", 1'b0, 12'h000, 32'h0,        32'h0,         1'b0},
        '{"R13", 1'b1, 12'h008, 32'h0000_000F, 32'h0,        1'b0},
        '{"R13", 1'b0, 12'h008, 32'h0,        32'h0000_0003, 1'b0},
        '{"R13", 1'b1, 12'h008, 32'h0000_0002, 32'h0,        1'b0},
        '{"R13", 1'b0, 12'h008, 32'h0,        32'h0,         1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_valid, bus_write;
    logic [11:0]     bus_addr;
    logic [31:0]     bus_wdata;
    logic            rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic            tx_idle, rx_idle;
    logic [N_EV-1:0] ev_in;
    logic            tx_en, rx_en, tx_kick, rx_kick, tx_rst, rx_rst, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic        got_valid, got_err, got_txk, got_rxk, got_txr, got_rxr;
    logic [31:0] got_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nic_ctrl_regs #(.N_EV(N_EV)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tx_idle(tx_idle), .rx_idle(rx_idle), .ev_in(ev_in),
        .tx_en(tx_en), .rx_en(rx_en), .tx_kick(tx_kick), .rx_kick(rx_kick),
        .tx_rst(tx_rst), .rx_rst(rx_rst), .irq(irq)
    );

    task automatic chk(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access: drive after a falling edge, sample at the next falling edge
    task automatic bus_op(input logic w, input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        got_valid = rsp_valid; got_data = rsp_rdata; got_err = rsp_err;
        got_txk = tx_kick; got_rxk = rx_kick; got_txr = tx_rst; got_rxr = rx_rst;
    endtask

    task automatic rd_chk(input logic [23:0] tag, input logic [11:0] a, input logic [31:0] exp);
        bus_op(1'b0, a, 32'h0);
        chk(tag, got_data, exp);
    endtask

    task automatic ev_pulse(input logic [N_EV-1:0] v);
        ev_in = v;
        @(negedge clk);
        ev_in = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        tx_idle = 1'b1; rx_idle = 1'b1; ev_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R7 defaults, R4 no response without access)
        chk("R4 ", {31'b0, rsp_valid}, 32'h0);
        chk("R7 ", {26'b0, tx_en, rx_en, tx_kick, rx_kick, tx_rst, rx_rst}, 32'h0);
        chk("R10", {31'b0, irq}, 32'h0);

        // table walk (R4 response strobe on every access)
        for (int i = 0; i < N_VEC; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            chk("R4 ", {31'b0, got_valid}, 32'h1);
            chk(VECS[i].tag, {31'b0, got_err}, {31'b0, VECS[i].exp_err});
            chk(VECS[i].tag, got_data, VECS[i].exp);
        end

        // R6: both on bits with engines idle -> enables and kicks
        bus_op(1'b1, 12'h000, 32'h005);
        chk("R6 ", {28'b0, got_txk, got_rxk, tx_en, rx_en}, 32'hF);
        rd_chk("R5 ", 12'h000, 32'h005);

        // R6/R7: off bits beat on bits, engine reset pulses, R5 read masking
        bus_op(1'b1, 12'h000, 32'h03F);
        chk("R6 ", {28'b0, got_txk, got_rxk, tx_en, rx_en}, 32'h0);
        chk("R7 ", {30'b0, got_txr, got_rxr}, 32'h3);
        rd_chk("R5 ", 12'h000, 32'h005);

        // R6: enabling a busy engine sets the enable without a kick
        tx_idle = 1'b0;
        bus_op(1'b1, 12'h000, 32'h001);
        chk("R6 ", {30'b0, tx_en, got_txk}, 32'h2);

        // R12: pointer write while transmitter busy is rejected
        bus_op(1'b1, 12'h018, 32'h0000_0040);
        chk("R12", {31'b0, got_err}, 32'h1);
        rd_chk("R12", 12'h018, 32'h1234_5674);
        tx_idle = 1'b1;

        // R8/R10: software interrupt raises the request; R9 read clears it
        bus_op(1'b1, 12'h010, 32'h100);
        bus_op(1'b1, 12'h014, 32'h1);
        bus_op(1'b1, 12'h000, 32'h080);
        chk("R8 ", {31'b0, irq}, 32'h1);
        rd_chk("R9 ", 12'h00C, 32'h100);
        chk("R9 ", {31'b0, irq}, 32'h0);
        rd_chk("R9 ", 12'h00C, 32'h0);

        // R9: writing status is an error without effect
        bus_op(1'b1, 12'h00C, 32'hFFFF_FFFF);
        chk("R9 ", {31'b0, got_err}, 32'h1);
        rd_chk("R9 ", 12'h00C, 32'h0);

        // R9: event in the same cycle as the clearing read survives
        bus_op(1'b1, 12'h010, 32'h104);
        ev_in = 8'h04;
        bus_op(1'b0, 12'h00C, 32'h0);
        ev_in = '0;
        chk("R9 ", got_data, 32'h0);
        chk("R10", {31'b0, irq}, 32'h1);
        rd_chk("R9 ", 12'h00C, 32'h4);

        // R10: masked event gives no request until unmasked; enable gates it
        ev_pulse(8'h08);
        chk("R10", {31'b0, irq}, 32'h0);
        bus_op(1'b1, 12'h010, 32'h10C);
        chk("R10", {31'b0, irq}, 32'h1);
        bus_op(1'b1, 12'h014, 32'h0);
        chk("R10", {31'b0, irq}, 32'h0);
        rd_chk("R9 ", 12'h00C, 32'h8);

        // R7: global reset beats an on bit and restores all defaults
        bus_op(1'b1, 12'h004, 32'hFFFF_FFFF);
        bus_op(1'b1, 12'h014, 32'h1);
        bus_op(1'b1, 12'h010, 32'hFFFF);
        bus_op(1'b1, 12'h008, 32'h1);
        ev_pulse(8'h01);
        chk("R10", {31'b0, irq}, 32'h1);
        bus_op(1'b1, 12'h000, 32'h101);
        chk("R7 ", {26'b0, got_txr, got_rxr, tx_en, rx_en, got_txk, irq}, 32'h30);
        rd_chk("R7 ", 12'h000, 32'h0);
        rd_chk("R7 ", 12'h004, 32'h0000_1005);
        rd_chk("R7 ", 12'h010, 32'h0);
        rd_chk("R7 ", 12'h008, 32'h0);
        rd_chk("R7 ", 12'h018, 32'h0);
        rd_chk("R7 ", 12'h00C, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule